// File: doc/BRIEF.md
# Configurable Serial Character Receiver

This block receives asynchronous serial characters on an idle-high line. Software sets the character length (5 to 9 data bits) and the parity mode (none, even or odd) through two configuration fields, which are held steady while a character is being received. A pulse at sixteen times the bit rate paces all bit timing. The baud-rate source sits outside the block.

For each character the block passes the serial input through a two-flop synchronizer. A falling edge opens a frame, and the start bit is confirmed at its middle. Each data bit, an optional parity bit and one stop bit are then sampled at their centres. The block delivers the data word right-aligned, together with a one-cycle valid strobe. In the same cycle it raises a parity-error flag and a frame-error flag when they apply. Only one stop bit is ever checked, so a transmitter that sends two stop bits works with it unchanged.

Top module: `serial_rx`

## Requirements
- R1: After a synchronous reset, and after a reset applied in the middle of a frame, `rx_valid`, `parity_err` and `frame_err` read 0, and no character is delivered for the interrupted frame.
- R2: The input passes through two synchronizer flops before falling-edge detection. The line is sampled again 8 ticks after the edge is seen. If it is high at that point the frame is dropped and nothing is delivered, so a low pulse of 7 tick periods or less produces no output.
- R3: Each later bit is sampled 16 ticks after the previous sample, and data arrives LSB first. With `os_tick` held high, `rx_valid` is high for exactly one clock, starting 11 + 16·N clock edges after the first edge that sees the line low. N counts the data bits, the parity bit if present, and the stop bit.
- R4: The `char_size` field selects the data length: 000 gives 5 bits, 001 gives 6, 010 gives 7, 011 gives 8 and 111 gives 9. `rx_data` is right-aligned and every bit above the selected length reads 0.
- R5: The `char_size` codes 100, 101 and 110 are reserved and receive 8 data bits.
- R6: The `parity_mode` field selects parity: 10 is even, so the parity bit equals the XOR of the data bits, and 11 is odd, so it equals the inverted XOR. When the received parity bit does not match, `parity_err` is 1 in the `rx_valid` cycle.
- R7: With `parity_mode` set to 00 (off) or 01 (reserved), no parity bit is expected and `parity_err` stays 0.
- R8: Only the first stop bit is checked. If it is sampled low, `frame_err` is 1 in the `rx_valid` cycle. A new start bit may begin as soon as that single stop bit ends.
- R9: `parity_err` and `frame_err` are valid only with `rx_valid`. Both read 0 in every other cycle, and they are freshly computed for each character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversampling pulse, 16 per bit period |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| char_size | input | 3 | Data-length code |
| parity_mode | input | 2 | Parity selection code |
| rx_data | output | MAX_BITS | Received word, right-aligned |
| rx_valid | output | 1 | One-cycle strobe for a received character |
| parity_err | output | 1 | Parity mismatch for the strobed character |
| frame_err | output | 1 | Stop bit sampled low for the strobed character |

## Verification
All three results of a character are due in one cycle: 11 + 16·N edges after the line falls. The two synchronizer stages, the edge register and the half-bit start check account for the 11 edges, and each further bit adds 16. The bench records the cycle in which each frame begins, queues the delivery cycle it expects, and compares the ports at every falling clock edge. It requires the strobe and the frame's data and flags in exactly the queued cycle, and requires a quiet strobe with both flags clear in every other cycle. Dropped glitches, reserved codes and reset in mid-frame therefore show up as a strobe that is missing or arrives at the wrong time.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_t;

  // data-length code to bit count; reserved codes fall back to 8
  function automatic logic [3:0] size_to_bits(input logic [2:0] code);
    case (code)
      3'b000:  return 4'd5;
      3'b001:  return 4'd6;
      3'b010:  return 4'd7;
      3'b111:  return 4'd9;
      default: return 4'd8;
    endcase
  endfunction

  // upper bit set means a parity bit is present (10 even, 11 odd)
  function automatic logic parity_present(input logic [1:0] mode);
    return mode[1];
  endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prev  <= chain[STAGES-1];
    end
  end

  assign dout = chain[STAGES-1];
  assign fall = prev & ~chain[STAGES-1];
endmodule

// File: rtl/rx_parity_chk.sv
module rx_parity_chk #(
  parameter int W = 9
) (
  input  logic [W-1:0] word,
  input  logic         odd,
  input  logic         rx_bit,
  output logic         mismatch
);
  logic expect_bit;

  // unused high bits of word are zero, so the whole vector can be reduced
  assign expect_bit = (^word) ^ odd;
  assign mismatch   = rx_bit ^ expect_bit;
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import serial_rx_pkg::*;
#(
  parameter int MAX_BITS = 9,
  parameter int OS_RATE  = 16,
  localparam int IDX_W   = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                line,
  input  logic                fall,
  input  logic [IDX_W-1:0]    nbits,
  input  logic                par_en,
  input  logic                par_odd,
  output logic [MAX_BITS-1:0] data_o,
  output logic                valid_o,
  output logic                perr_o,
  output logic                ferr_o
);
  localparam int CNT_W = $clog2(OS_RATE);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OS_RATE / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OS_RATE - 1);

  rx_state_t           state;
  logic [CNT_W-1:0]    cnt;
  logic [IDX_W-1:0]    idx;
  logic [MAX_BITS-1:0] shreg;
  logic                pbit;
  logic                mismatch;

  rx_parity_chk #(.W(MAX_BITS)) u_par (
    .word    (shreg),
    .odd     (par_odd),
    .rx_bit  (pbit),
    .mismatch(mismatch)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      idx     <= '0;
      shreg   <= '0;
      pbit    <= 1'b0;
      data_o  <= '0;
      valid_o <= 1'b0;
      perr_o  <= 1'b0;
      ferr_o  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      perr_o  <= 1'b0;
      ferr_o  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (fall) begin
            state <= ST_START;
            cnt   <= '0;
          end
        end
        ST_START: begin
          if (tick) begin
            if (cnt == MID_CNT) begin
              cnt <= '0;
              if (line) begin
                state <= ST_IDLE;
              end else begin
                state <= ST_DATA;
                idx   <= '0;
                shreg <= '0;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (tick) begin
            if (cnt == LAST_CNT) begin
              cnt        <= '0;
              shreg[idx] <= line;
              if (idx == nbits - 1'b1) begin
                state <= par_en ? ST_PAR : ST_STOP;
              end else begin
                idx <= idx + 1'b1;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_PAR: begin
          if (tick) begin
            if (cnt == LAST_CNT) begin
              cnt   <= '0;
              pbit  <= line;
              state <= ST_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_STOP: begin
          if (tick) begin
            if (cnt == LAST_CNT) begin
              cnt     <= '0;
              state   <= ST_IDLE;
              valid_o <= 1'b1;
              data_o  <= shreg;
              ferr_o  <= ~line;
              perr_o  <= par_en & mismatch;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serial_rx.sv
module serial_rx
  import serial_rx_pkg::*;
#(
  parameter int MAX_BITS    = 9,
  parameter int OS_RATE     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                os_tick,
  input  logic                rx_in,
  input  logic [2:0]          char_size,
  input  logic [1:0]          parity_mode,
  output logic [MAX_BITS-1:0] rx_data,
  output logic                rx_valid,
  output logic                parity_err,
  output logic                frame_err
);
  localparam int IDX_W = $clog2(MAX_BITS + 1);

  logic             line_s;
  logic             line_fall;
  logic [IDX_W-1:0] nbits;
  logic             par_en;

  assign nbits  = IDX_W'(size_to_bits(char_size));
  assign par_en = parity_present(parity_mode);

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (rx_in),
    .dout(line_s),
    .fall(line_fall)
  );

  rx_frame_fsm #(.MAX_BITS(MAX_BITS), .OS_RATE(OS_RATE)) u_fsm (
    .clk    (clk),
    .rst    (rst),
    .tick   (os_tick),
    .line   (line_s),
    .fall   (line_fall),
    .nbits  (nbits),
    .par_en (par_en),
    .par_odd(parity_mode[0]),
    .data_o (rx_data),
    .valid_o(rx_valid),
    .perr_o (parity_err),
    .ferr_o (frame_err)
  );
endmodule

// File: rtl/serial_rx_checker.sv
module serial_rx_checker #(
  parameter int MAX_BITS = 9
) (
  input logic                clk,
  input logic                rst,
  input logic [2:0]          char_size,
  input logic [1:0]          parity_mode,
  input logic [MAX_BITS-1:0] rx_data,
  input logic                rx_valid,
  input logic                parity_err,
  input logic                frame_err
);
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !rx_valid);

  p_strobe_single_r3: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  p_zero_fill_r4: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && $past(char_size) == 3'b000) |-> (rx_data[MAX_BITS-1:5] == '0));

  p_no_parity_flag_r7: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !$past(parity_mode[1])) |-> !parity_err);

  p_flags_with_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |-> (!parity_err && !frame_err));
endmodule

bind serial_rx serial_rx_checker #(.MAX_BITS(MAX_BITS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .char_size  (char_size),
  .parity_mode(parity_mode),
  .rx_data    (rx_data),
  .rx_valid   (rx_valid),
  .parity_err (parity_err),
  .frame_err  (frame_err)
);

// File: tb/serial_rx_bench.sv
module serial_rx_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       os_tick = 1'b1;
  logic       rx_in = 1'b1;
  logic [2:0] char_size = 3'b011;
  logic [1:0] parity_mode = 2'b00;
  logic [8:0] rx_data;
  logic       rx_valid;
  logic       parity_err;
  logic       frame_err;

  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";

  typedef struct {
    int         at;
    logic [8:0] data;
    bit         perr;
    bit         ferr;
    string      req;
  } exp_t;
  exp_t q[$];

  serial_rx u_serial_rx (
    .clk(clk), .rst(rst), .os_tick(os_tick), .rx_in(rx_in),
    .char_size(char_size), .parity_mode(parity_mode),
    .rx_data(rx_data), .rx_valid(rx_valid),
    .parity_err(parity_err), .frame_err(frame_err)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // data-length table as stated in R4 and R5
  function automatic int len_of(input logic [2:0] code);
    case (code)
      3'b000:  return 5;
      3'b001:  return 6;
      3'b010:  return 7;
      3'b111:  return 9;
      default: return 8;
    endcase
  endfunction

  // per-clock comparison against the queued expectations
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (q.size() != 0 && q[0].at == cyc) begin
        if (!rx_valid || rx_data !== q[0].data ||
            parity_err !== q[0].perr || frame_err !== q[0].ferr) begin
          errors++;
          $display("FAIL %s cyc %0d: got v=%b d=%h pe=%b fe=%b exp v=1 d=%h pe=%b fe=%b",
                   q[0].req, cyc, rx_valid, rx_data, parity_err, frame_err,
                   q[0].data, q[0].perr, q[0].ferr);
        end
        void'(q.pop_front());
      end else if (rx_valid !== 1'b0 || parity_err !== 1'b0 || frame_err !== 1'b0) begin
        errors++;
        $display("FAIL %s/R9 cyc %0d: got v=%b pe=%b fe=%b exp v=0 pe=0 fe=0",
                 cur_req, cyc, rx_valid, parity_err, frame_err);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // called at a negedge; drives one whole frame, returns at a negedge
  task automatic send_frame(input logic [8:0] d, input bit bad_par,
                            input bit stop_v, input string req);
    int         n = len_of(char_size);
    bit         pen = parity_mode[1];
    logic [8:0] dm = d & 9'((1 << n) - 1);
    bit         pb = (^dm) ^ parity_mode[0] ^ bad_par;
    int         nb = n + (pen ? 1 : 0) + 1;
    exp_t       e;
    cur_req = req;
    e.at = cyc + 11 + 16 * nb;
    e.data = dm;
    e.perr = pen & bad_par;
    e.ferr = ~stop_v;
    e.req = req;
    q.push_back(e);
    rx_in = 1'b0;
    idle(16);
    for (int i = 0; i < n; i++) begin
      rx_in = d[i];
      idle(16);
    end
    if (pen) begin
      rx_in = pb;
      idle(16);
    end
    rx_in = stop_v;
    idle(16);
    rx_in = 1'b1;
  endtask

  task automatic cfg(input logic [2:0] cs, input logic [1:0] pm);
    char_size = cs;
    parity_mode = pm;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got hang exp completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    checks++;
    if (rx_valid !== 1'b0 || parity_err !== 1'b0 || frame_err !== 1'b0) begin
      errors++;
      $display("FAIL R1: got v=%b pe=%b fe=%b exp 0 0 0", rx_valid, parity_err, frame_err);
    end
    rst = 1'b0;
    idle(5);

    cfg(3'b011, 2'b00); send_frame(9'h0A5, 0, 1, "R3"); idle(10);
    cfg(3'b000, 2'b00); send_frame(9'h1FF, 0, 1, "R4"); idle(10);
    cfg(3'b001, 2'b10); send_frame(9'h02D, 0, 1, "R6"); idle(10);
    cfg(3'b010, 2'b11); send_frame(9'h053, 0, 1, "R6"); idle(10);
    cfg(3'b111, 2'b10); send_frame(9'h1C3, 0, 1, "R6"); idle(10);
    cfg(3'b111, 2'b11); send_frame(9'h0F0, 1, 1, "R6"); idle(10);
    cfg(3'b011, 2'b10); send_frame(9'h03C, 0, 1, "R9"); idle(10);
    cfg(3'b011, 2'b00); send_frame(9'h05A, 0, 0, "R8"); idle(10);
    cfg(3'b011, 2'b11); send_frame(9'h066, 1, 0, "R9"); idle(10);
    cfg(3'b101, 2'b00); send_frame(9'h1E7, 0, 1, "R5"); idle(10);
    cfg(3'b110, 2'b00); send_frame(9'h133, 0, 1, "R5"); idle(10);
    cfg(3'b010, 2'b01); send_frame(9'h02A, 0, 1, "R7"); idle(10);
    cfg(3'b011, 2'b00); send_frame(9'h099, 1, 1, "R7"); idle(10);
    // R8: back-to-back frames after a single stop bit
    cfg(3'b011, 2'b00);
    send_frame(9'h081, 0, 1, "R8");
    send_frame(9'h07E, 0, 1, "R8");
    idle(10);
    // R2: short low pulses are dropped
    cur_req = "R2";
    rx_in = 1'b0; idle(4); rx_in = 1'b1; idle(40);
    rx_in = 1'b0; idle(7); rx_in = 1'b1; idle(40);
    // R1: reset in the middle of a frame
    cur_req = "R1";
    rx_in = 1'b0; idle(40);
    rx_in = 1'b1; rst = 1'b1; idle(3);
    rst = 1'b0; idle(200);
    // receiver still works after that reset
    send_frame(9'h0C4, 0, 1, "R1"); idle(20);

    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R3: got %0d undelivered frames exp 0", q.size());
    end
    finish_run();
  end
endmodule